// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block drives four independent pulse-width modulated outputs, programmed through a small memory-mapped register bus with a 12-bit byte address and 32-bit data. Each channel owns a clock divider, a 16-bit position counter, a polarity choice, and a live period and inactive-length pair. Each period opens at the inactive level. The output switches to the active level once the programmed inactive count has elapsed, so the active share of a period is the period minus the inactive length.

Software starts and stops channels by writing one-hot masks to two global strobe registers. While a channel is running, its timing is changed only through staging registers. A staged value is copied into the live one at the next period boundary, so an output never shows a period that mixes old and new settings. Every period boundary raises a per-channel flag. Reading the flag register returns the flags and clears them in the same access. A stop request lets the current period finish before the channel halts.

Top module: `pwm_quad`

## Requirements
- R1: After reset every output is low, and the status (0x00C) and flag (0x01C) registers read 0.
- R2: Channel n's registers sit at 0x200 + 32*n, with mode at +0x00, inactive length at +0x04, staged inactive length at +0x08, period at +0x0C and staged period at +0x10. All five read back what was written. Any other address reads 0, and a write to any other address changes nothing.
- R3: Mode bits [3:0] select a divider of 2^value, and the position counter advances once per that many clocks. A mode write with a divider value above 10 keeps the previous divider.
- R4: Mode bit 9 set to 0 makes the active level high. Set to 1, it inverts the output. The inactive level is the value of bit 9.
- R5: With period P>0 and inactive length D, position k of each period (0..P-1) is active when k>=D. D=0 gives a fully active period, D>=P gives a fully inactive one, and P=0 holds the output inactive.
- R6: Writing 1 to bit n at 0x004 starts a stopped channel n, with position 0 in the first clock after the write. Status bit n reads 1 while the channel runs. No channel starts without such a write.
- R7: Writing 1 to bit n at 0x008 stops channel n only at the end of its current period. The status bit stays 1 until that point, and after it the output rests at the inactive level.
- R8: Direct writes to mode, inactive length or period are ignored while the channel runs.
- R9: Staged values are copied to the live registers at the next period end and are readable before that. A direct write made while stopped cancels any pending staged copy of the same field.
- R10: Flag bit n sets at every period end of channel n. A read of 0x01C returns the flags and clears them, except that a flag setting in the same cycle survives the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, used for clear-on-read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally for bus_addr |
| pwm_out | output | 4 | Channel outputs |

## Verification
The assertions check the control rules on every cycle. A flag must follow each period end, and a read with no coincident period end must empty the flag register. A running channel may halt only at a period end, an idle channel may start only after an enable write for its bit, and unmapped addresses must read 0. The exact waveform can only be shown by the bench scenarios, which compare each output cycle by cycle against a closed-form model. Those scenarios also cover divider scaling up to 2^10, the zero-period and zero-length edges, polarity, the timing of staged loads, and the exact boundary at which a stop request takes effect.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int PRES_W    = 4;
  localparam int POL_BIT   = 9;

  // global strobe and status addresses
  localparam logic [ADDR_W-1:0] ADDR_ENA  = 12'h004;
  localparam logic [ADDR_W-1:0] ADDR_DIS  = 12'h008;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 12'h01C;

  // per-channel window
  localparam logic [ADDR_W-1:0] CH_BASE   = 12'h200;
  localparam int                CH_STRIDE = 32;
  localparam int                OFF_W     = $clog2(CH_STRIDE);

  localparam logic [OFF_W-1:0] OFF_MODE    = 5'h00;
  localparam logic [OFF_W-1:0] OFF_LEN     = 5'h04;
  localparam logic [OFF_W-1:0] OFF_LEN_STG = 5'h08;
  localparam logic [OFF_W-1:0] OFF_PER     = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_PER_STG = 5'h10;
endpackage

// File: rtl/pwmc_prescale.sv
module pwmc_prescale #(
  parameter int PRES_MAX = 10,
  parameter int PRES_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [PRES_W-1:0] pres,
  output logic              tick
);
  logic [PRES_MAX-1:0] pcnt_q, pcnt_n;
  logic [PRES_MAX:0]   span;

  always_comb begin
    span = ({{PRES_MAX{1'b0}}, 1'b1} << pres) - 1'b1;
    tick = run && ((pcnt_q & span[PRES_MAX-1:0]) == span[PRES_MAX-1:0]);
  end

  always_comb begin
    pcnt_n = pcnt_q;
    if (clr)      pcnt_n = '0;
    else if (run) pcnt_n = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_n;
  end
endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
  import pwmc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              start_req,
  input  logic              stop_req,
  output logic              running,
  output logic              period_end,
  output logic              pwm
);
  logic              run_q, run_n, halt_q, halt_n, pol_q, pol_n;
  logic [PRES_W-1:0] pres_q, pres_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, len_q, len_n, per_q, per_n;
  logic [CNT_W-1:0]  len_st_q, len_st_n, per_st_q, per_st_n;
  logic              len_pd_q, len_pd_n, per_pd_q, per_pd_n;
  logic              tick, active;

  pwmc_prescale #(.PRES_MAX(PRES_MAX), .PRES_W(PRES_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(start_req && !run_q),
    .run(run_q), .pres(pres_q), .tick(tick)
  );

  assign period_end = run_q && tick && ((per_q == '0) || (cnt_q == per_q - 1'b1));
  assign active     = (per_q != '0) && (cnt_q >= len_q);
  assign running    = run_q;
  assign pwm        = run_q ? (active ^ pol_q) : pol_q;

  always_comb begin
    run_n = run_q;  halt_n = halt_q;  cnt_n = cnt_q;
    pres_n = pres_q; pol_n = pol_q;  len_n = len_q;  per_n = per_q;
    len_st_n = len_st_q; per_st_n = per_st_q;
    len_pd_n = len_pd_q; per_pd_n = per_pd_q;

    if (start_req) begin
      if (!run_q) begin
        run_n = 1'b1;
        cnt_n = '0;
      end
      halt_n = 1'b0;
    end else if (stop_req && run_q) begin
      halt_n = 1'b1;
    end

    if (run_q && tick) cnt_n = period_end ? '0 : cnt_q + 1'b1;

    if (period_end) begin
      if (len_pd_q) begin len_n = len_st_q; len_pd_n = 1'b0; end
      if (per_pd_q) begin per_n = per_st_q; per_pd_n = 1'b0; end
      if (halt_q)   begin run_n = 1'b0;     halt_n   = 1'b0; end
    end

    if (reg_wr) begin
      unique case (reg_off)
        OFF_MODE: if (!run_q) begin
          pol_n = reg_wdata[POL_BIT];
          if (reg_wdata[PRES_W-1:0] <= PRES_W'(PRES_MAX)) pres_n = reg_wdata[PRES_W-1:0];
        end
        OFF_LEN: if (!run_q) begin
          len_n = reg_wdata[CNT_W-1:0];
          len_pd_n = 1'b0;
        end
        OFF_PER: if (!run_q) begin
          per_n = reg_wdata[CNT_W-1:0];
          per_pd_n = 1'b0;
        end
        OFF_LEN_STG: begin len_st_n = reg_wdata[CNT_W-1:0]; len_pd_n = 1'b1; end
        OFF_PER_STG: begin per_st_n = reg_wdata[CNT_W-1:0]; per_pd_n = 1'b1; end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_off)
      OFF_MODE:    begin reg_rdata[POL_BIT] = pol_q; reg_rdata[PRES_W-1:0] = pres_q; end
      OFF_LEN:     reg_rdata[CNT_W-1:0] = len_q;
      OFF_LEN_STG: reg_rdata[CNT_W-1:0] = len_st_q;
      OFF_PER:     reg_rdata[CNT_W-1:0] = per_q;
      OFF_PER_STG: reg_rdata[CNT_W-1:0] = per_st_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; halt_q <= 1'b0; pol_q <= 1'b0; pres_q <= '0;
      cnt_q <= '0; len_q <= '0; per_q <= '0; len_st_q <= '0; per_st_q <= '0;
      len_pd_q <= 1'b0; per_pd_q <= 1'b0;
    end else begin
      run_q <= run_n; halt_q <= halt_n; pol_q <= pol_n; pres_q <= pres_n;
      cnt_q <= cnt_n; len_q <= len_n; per_q <= per_n; len_st_q <= len_st_n;
      per_st_q <= per_st_n; len_pd_q <= len_pd_n; per_pd_q <= per_pd_n;
    end
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwmc_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CNT_W    = 16,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int                IDX_W   = $clog2(NCH);
  localparam logic [ADDR_W-1:0] CH_SPAN = ADDR_W'(NCH * CH_STRIDE);

  logic              rst_s1, rst_s;
  logic [ADDR_W-1:0] ch_off;
  logic              in_ch;
  logic [IDX_W-1:0]  ch_idx;
  logic [NCH-1:0]    start_vec, stop_vec, run_vec, pend_vec;
  logic [NCH-1:0]    flag_q, flag_n, flag_clr;
  logic [DATA_W-1:0] ch_rdata [NCH];

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_s1 <= 1'b0; rst_s <= 1'b0; end
    else        begin rst_s1 <= 1'b1; rst_s <= rst_s1; end
  end

  assign ch_off    = bus_addr - CH_BASE;
  assign in_ch     = (bus_addr >= CH_BASE) && (ch_off < CH_SPAN);
  assign ch_idx    = ch_off[OFF_W +: IDX_W];
  assign start_vec = (bus_wr && bus_addr == ADDR_ENA) ? bus_wdata[NCH-1:0] : '0;
  assign stop_vec  = (bus_wr && bus_addr == ADDR_DIS) ? bus_wdata[NCH-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmc_chan #(.CNT_W(CNT_W), .PRES_MAX(PRES_MAX)) u_ch (
      .clk(clk), .rst_n(rst_s),
      .reg_wr(bus_wr && in_ch && (ch_idx == IDX_W'(g))),
      .reg_off(ch_off[OFF_W-1:0]), .reg_wdata(bus_wdata), .reg_rdata(ch_rdata[g]),
      .start_req(start_vec[g]), .stop_req(stop_vec[g]),
      .running(run_vec[g]), .period_end(pend_vec[g]), .pwm(pwm_out[g])
    );
  end

  always_comb begin
    flag_clr = {NCH{bus_rd && bus_addr == ADDR_FLAG}};
    flag_n   = (flag_q & ~flag_clr) | pend_vec;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_STAT)      bus_rdata[NCH-1:0] = run_vec;
    else if (bus_addr == ADDR_FLAG) bus_rdata[NCH-1:0] = flag_q;
    else if (in_ch)                 bus_rdata = ch_rdata[ch_idx];
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwmc_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    run_vec,
  input logic [NCH-1:0]    pend_vec,
  input logic [NCH-1:0]    flag_q
);
  for (genvar n = 0; n < NCH; n++) begin : g_prop
    AST_FLAG_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vec[n] |=> flag_q[n]); // R10
    AST_HALT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (run_vec[n] && !pend_vec[n]) |=> run_vec[n]); // R7
    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_vec[n] && !(bus_wr && bus_addr == ADDR_ENA && bus_wdata[n])) |=> !run_vec[n]); // R6
  end

  AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_FLAG && pend_vec == '0) |=> (flag_q == '0)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 12'h020 && bus_addr < CH_BASE) |-> (bus_rdata == '0)); // R2
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .run_vec(run_vec), .pend_vec(pend_vec), .flag_q(flag_q)
);

// File: tb/pwm_quad_tb_top.sv
`timescale 1ns/1ps
module pwm_quad_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int          checks = 0, fails = 0;
  bit          done = 1'b0;
  int unsigned cyc = 0;
  bit          pol_t [4];

  pwm_quad dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // all bus tasks begin and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [11:0] chaddr(input int c, input int off);
    return 12'(32'h200 + c * 32 + off);
  endfunction

  function automatic bit exp_lvl(input int k, input int per, input int len, input int p, input bit pol);
    int pos;
    if (per == 0) return pol;
    pos = (k >> p) % per;
    return (pos >= len) ^ pol;
  endfunction

  task automatic trial(input int c, input int per, input int len, input int p, input bit pol);
    int unsigned s;
    int span;
    logic [31:0] v;
    string tag;
    tag = (p != 0) ? "R3" : (pol ? "R4" : "R5");
    wr(chaddr(c, 0), (32'(pol) << 9) | 32'(p));
    wr(chaddr(c, 4), 32'(len));
    wr(chaddr(c, 12), 32'(per));
    pol_t[c] = pol;
    wr(12'h004, 32'(1) << c);
    s = cyc;
    span = (per == 0) ? 20 : 2 * (per << p) + 2;
    for (int i = 0; i < span; i++) begin
      int k;
      k = int'(cyc - s);
      chk(pwm_out[c] == exp_lvl(k, per, len, p, pol), tag, pwm_out[c], exp_lvl(k, per, len, p, pol));
      for (int o = 0; o < 4; o++)
        if (o != c) chk(pwm_out[o] == pol_t[o], "R4", pwm_out[o], pol_t[o]);
      @(negedge clk);
    end
    wr(12'h008, 32'(1) << c);
    v = '1;
    for (int i = 0; i < ((per + 1) << p) + 8 && v[c]; i++) rd(12'h00C, v);
    chk(v[c] == 1'b0, "R7", v[c], 0);
    chk(pwm_out[c] == pol, "R7", pwm_out[c], pol);
  endtask

  initial begin
    logic [31:0] v;
    int unsigned s;
    int kz;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) pol_t[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(pwm_out == 4'b0, "R1", pwm_out, 0);
    rd(12'h00C, v); chk(v == 0, "R1", v, 0);
    rd(12'h01C, v); chk(v == 0, "R1", v, 0);

    // R2 register map and readback on channel 3
    wr(chaddr(3, 0), 32'h205);
    rd(chaddr(3, 0), v);  chk(v == 32'h205, "R2", v, 32'h205);
    wr(chaddr(3, 4), 32'h1234);  wr(chaddr(3, 12), 32'hBEEF);
    wr(chaddr(3, 8), 32'h0055);  wr(chaddr(3, 16), 32'h0066);
    rd(chaddr(3, 4), v);  chk(v == 32'h1234, "R2", v, 32'h1234);
    rd(chaddr(3, 12), v); chk(v == 32'hBEEF, "R2", v, 32'hBEEF);
    rd(chaddr(3, 8), v);  chk(v == 32'h0055, "R2", v, 32'h0055);
    rd(chaddr(3, 16), v); chk(v == 32'h0066, "R2", v, 32'h0066);
    wr(chaddr(3, 20), 32'hFFFF);
    rd(chaddr(3, 12), v); chk(v == 32'hBEEF, "R2", v, 32'hBEEF);
    rd(chaddr(3, 20), v); chk(v == 0, "R2", v, 0);
    rd(12'h100, v);       chk(v == 0, "R2", v, 0);
    rd(12'h004, v);       chk(v == 0, "R2", v, 0);
    // R3 divider value above the limit keeps the old divider
    wr(chaddr(3, 0), 32'h20B);
    rd(chaddr(3, 0), v);  chk(v == 32'h205, "R3", v, 32'h205);
    pol_t[3] = 1'b1;
    chk(pwm_out[3] == 1'b1, "R4", pwm_out[3], 1);

    // directed edges, then random configurations (R5, R3, R4)
    trial(0, 5, 0, 0, 1'b0);
    trial(1, 0, 3, 1, 1'b1);
    trial(2, 4, 6, 0, 1'b0);
    trial(3, 3, 1, 10, 1'b1);
    for (int t = 0; t < 24; t++) begin
      int per;
      per = int'($urandom_range(0, 24));
      trial(int'($urandom_range(0, 3)), per, int'($urandom_range(0, per + 2)),
            int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    // R9 staged updates and R8 ignored direct writes on channel 1
    wr(chaddr(1, 0), 32'h0); pol_t[1] = 1'b0;
    wr(chaddr(1, 4), 32'd4);
    wr(chaddr(1, 12), 32'd10);
    wr(12'h004, 32'h2);
    s = cyc;
    wr(chaddr(1, 8), 32'd7);
    wr(chaddr(1, 16), 32'd12);
    rd(chaddr(1, 8), v); chk(v == 7, "R9", v, 7);
    rd(chaddr(1, 4), v); chk(v == 4, "R9", v, 4);
    wr(chaddr(1, 4), 32'd2);
    wr(chaddr(1, 0), 32'h200);
    while (int'(cyc - s) < 34) begin
      int k;
      bit e;
      k = int'(cyc - s);
      e = (k < 10) ? exp_lvl(k, 10, 4, 0, 1'b0) : exp_lvl(k - 10, 12, 7, 0, 1'b0);
      chk(pwm_out[1] == e, "R9", pwm_out[1], e);
      @(negedge clk);
    end
    rd(chaddr(1, 4), v);  chk(v == 7, "R8", v, 7);
    rd(chaddr(1, 0), v);  chk(v == 0, "R8", v, 0);
    rd(chaddr(1, 12), v); chk(v == 12, "R9", v, 12);

    // R7 stop waits for the period boundary
    wr(12'h008, 32'h2);
    rd(12'h00C, v); chk(v[1] == 1'b1, "R7", v[1], 1);
    kz = 0;
    for (int i = 0; i < 40; i++) begin
      kz = int'(cyc - s);
      rd(12'h00C, v);
      if (!v[1]) break;
    end
    chk(v[1] == 1'b0, "R7", v[1], 0);
    chk(kz > 10 && (kz - 10) % 12 == 0, "R7", kz, 46);
    chk(pwm_out[1] == 1'b0, "R7", pwm_out[1], 0);

    // R10 flags, R6 status on channel 2
    rd(12'h01C, v);
    wr(chaddr(2, 0), 32'h0); pol_t[2] = 1'b0;
    wr(chaddr(2, 4), 32'd50);
    wr(chaddr(2, 12), 32'd200);
    wr(12'h004, 32'h4);
    rd(12'h00C, v); chk(v == 32'h4, "R6", v, 4);
    rd(12'h01C, v); chk(v == 0, "R10", v, 0);
    repeat (205) @(negedge clk);
    rd(12'h01C, v); chk(v == 32'h4, "R10", v, 4);
    rd(12'h01C, v); chk(v == 0, "R10", v, 0);
    wr(12'h008, 32'h4);
    for (int i = 0; i < 260 && v[2] !== 1'b0; i++) rd(12'h00C, v);
    v = '1;
    for (int i = 0; i < 260 && v[2]; i++) rd(12'h00C, v);
    chk(v[2] == 1'b0, "R7", v[2], 0);

    finish_run();
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule